// File: doc/BRIEF.md
# Wave Collective Operation Unit

This block carries out cross-lane operations for one wave of `LANES` lanes, each lane holding a 32-bit word. A single request carries an opcode, every lane's data word, a source lane index per lane, a broadcast source index, a per-lane predicate and the active mask. One cycle after the request is accepted, the unit presents a full result vector and a warning flag.

Five operation families are supported: shuffle, broadcast, integer reductions (add, signed min, signed max) and ballot. The active mask gates every operation. Only active lanes supply values, and only active lanes receive new results. An inactive lane's result slot keeps whatever value it last held. A shuffle or broadcast that names a source lane that is inactive, or that lies outside the wave, delivers zero and raises the warning flag.

Requests and results each use a valid/ready handshake. The result register is one entry deep. A new request is taken whenever that register is empty or is being drained in the same cycle.

Top module: `wave_collective_unit`

## Requirements
- R1: A request is accepted on a rising edge where `in_valid` and `in_ready` are both high, and `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. `out_valid` is high in the cycle after an acceptance. While `out_valid` is high and `out_ready` is low, `out_valid`, `result` and `warn` hold their values.
- R2: Opcode 0 (shuffle): every active lane i receives the word of lane `src_lane[i*IDX_W +: IDX_W]` when that source lane is active.
- R3: In a shuffle or broadcast, a source index that is at least `LANES`, or that names an inactive lane, gives zero to the requesting active lane. If at least one active lane hits such a source, `warn` is 1 with the result.
- R4: Opcode 1 (broadcast): every active lane receives the word of lane `bcast_lane`, subject to R3.
- R5: Opcode 2 (reduce-add): every active lane receives the sum of the active lanes' words, modulo 2^32.
- R6: Opcode 3 (reduce-min) and opcode 4 (reduce-max): every active lane receives the smallest or largest active word, compared as signed 32-bit integers.
- R7: An inactive lane's word never affects a reduction, even when that word is an extreme value. The neutral elements are 0 for add, 0x7FFFFFFF for min and 0x80000000 for max.
- R8: For every accepted request, the result slot of each inactive lane keeps its previous value.
- R9: Opcode 5 (ballot): every active lane receives a word whose bit j is 1 exactly when lane j is active and `pred[j]` is 1. Bits `LANES` and above are 0.
- R10: `warn` is 0 for every opcode other than shuffle and broadcast.
- R11: Opcodes 6 and 7 are still accepted and still produce a result, but no lane changes and `warn` is 0.
- R12: After reset, `out_valid`, `warn` and every bit of `result` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| op | input | 3 | Opcode (0 shuffle, 1 broadcast, 2 add, 3 min, 4 max, 5 ballot) |
| lane_data | input | LANES*32 | Per-lane data words; lane i at bits [i*32 +: 32] |
| src_lane | input | LANES*IDX_W | Per-lane shuffle source index, IDX_W = clog2(LANES)+1 |
| bcast_lane | input | IDX_W | Broadcast source lane |
| pred | input | LANES | Per-lane predicate for ballot |
| active | input | LANES | Active mask |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| result | output | LANES*32 | Per-lane result words |
| warn | output | 1 | Shuffle or broadcast read an unusable source |

## Verification
The following properties are checked on every cycle: the stall-hold rule, that `out_valid` follows an acceptance, that inactive lanes keep their result slots, that `warn` stays low outside shuffle and broadcast, and how lane 0 behaves for ballot and for out-of-range shuffles. The arithmetic itself can only be shown by the bench scenarios, which compare every result against an independent model. This covers shuffles between active lanes, modular wrap of the sum, signed ordering with inactive extreme values, broadcast from an inactive lane, and undefined opcodes.

// File: rtl/wcu_pkg.sv
// Shared definitions for the wave collective unit.
// Assumes a fixed 32-bit lane word; reductions are integer only.
package wcu_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        OP_SHUFFLE = 3'd0,
        OP_BCAST   = 3'd1,
        OP_RADD    = 3'd2,
        OP_RMIN    = 3'd3,
        OP_RMAX    = 3'd4,
        OP_BALLOT  = 3'd5
    } wcu_op_e;

    typedef enum logic [1:0] {
        RK_ADD = 2'd0,
        RK_MIN = 2'd1,
        RK_MAX = 2'd2
    } red_kind_e;

    // Neutral element that leaves a reduction unchanged.
    function automatic logic [WORD_W-1:0] red_identity(input red_kind_e kind);
        case (kind)
            RK_MIN:  return {1'b0, {(WORD_W-1){1'b1}}};
            RK_MAX:  return {1'b1, {(WORD_W-1){1'b0}}};
            default: return '0;
        endcase
    endfunction

    // Two-input combine step of a reduction; min/max are signed.
    function automatic logic [WORD_W-1:0] red_combine(input red_kind_e kind,
                                                      input logic [WORD_W-1:0] a,
                                                      input logic [WORD_W-1:0] b);
        case (kind)
            RK_MIN:  return ($signed(a) < $signed(b)) ? a : b;
            RK_MAX:  return ($signed(a) > $signed(b)) ? a : b;
            default: return a + b;
        endcase
    endfunction

endpackage

// File: rtl/wcu_xbar.sv
// Lane crossbar: each output lane picks the word of the lane named by its
// selector. Assumes selectors may exceed LANES-1; such selectors, and
// selectors naming an inactive lane, yield zero and raise the lane's bad flag.
module wcu_xbar #(
    parameter int LANES  = 8,
    parameter int IDX_W  = 4,
    parameter int WORD_W = 32
) (
    input  logic [LANES*WORD_W-1:0] data_in,
    input  logic [LANES*IDX_W-1:0]  sel_vec,
    input  logic [LANES-1:0]        active,
    output logic [LANES*WORD_W-1:0] picked,
    output logic [LANES-1:0]        bad
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [IDX_W-1:0]  sel;
        logic [WORD_W-1:0] pick;
        logic              hit;

        assign sel = sel_vec[l*IDX_W +: IDX_W];

        // One-hot style mux over all source lanes, gated by the active mask.
        always_comb begin
            pick = '0;
            hit  = 1'b0;
            for (int j = 0; j < LANES; j++) begin
                if (sel == IDX_W'(j) && active[j]) begin
                    pick = data_in[j*WORD_W +: WORD_W];
                    hit  = 1'b1;
                end
            end
        end

        assign picked[l*WORD_W +: WORD_W] = pick;
        assign bad[l]                     = ~hit;
    end

endmodule

// File: rtl/wcu_reduce.sv
// Balanced reduction tree over the active lanes. Inactive lanes and padding
// leaves enter as the neutral element of the chosen kind. Assumes LANES >= 2.
module wcu_reduce
    import wcu_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [LANES*WORD_W-1:0] data_in,
    input  logic [LANES-1:0]        active,
    input  red_kind_e               kind,
    output logic [WORD_W-1:0]       total
);

    localparam int LEVELS = $clog2(LANES);
    localparam int P2     = 1 << LEVELS;

    for (genvar l = 0; l <= LEVELS; l++) begin : lvl
        logic [WORD_W-1:0] v [P2 >> l];
        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < P2; k++) begin : g_k
                if (k < LANES) begin : g_real
                    // Active lanes feed their word, inactive ones the identity.
                    assign v[k] = active[k] ? data_in[k*WORD_W +: WORD_W]
                                            : red_identity(kind);
                end else begin : g_pad
                    // Padding up to a power of two.
                    assign v[k] = red_identity(kind);
                end
            end
        end else begin : g_node
            for (genvar k = 0; k < (P2 >> l); k++) begin : g_k
                // Pairwise combine of the level below.
                assign v[k] = red_combine(kind, lvl[l-1].v[2*k], lvl[l-1].v[2*k+1]);
            end
        end
    end

    assign total = lvl[LEVELS].v[0];

endmodule

// File: rtl/wave_collective_unit.sv
// Wave collective unit top. Accepts one cross-lane request per handshake and
// registers the full result vector. Only active lanes are written; inactive
// lanes keep the previous result. Assumes 2 <= LANES <= 32 so a ballot mask
// fits in one word.
module wave_collective_unit
    import wcu_pkg::*;
#(
    parameter  int LANES = 8,
    localparam int IDX_W = $clog2(LANES) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [2:0]              op,
    input  logic [LANES*WORD_W-1:0] lane_data,
    input  logic [LANES*IDX_W-1:0]  src_lane,
    input  logic [IDX_W-1:0]        bcast_lane,
    input  logic [LANES-1:0]        pred,
    input  logic [LANES-1:0]        active,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*WORD_W-1:0] result,
    output logic                    warn
);

    wcu_op_e                 op_e;
    logic                    accept;
    logic                    is_xfer;
    logic [LANES*IDX_W-1:0]  sel_vec;
    logic [LANES*WORD_W-1:0] picked;
    logic [LANES-1:0]        bad;
    red_kind_e               kind;
    logic [WORD_W-1:0]       total;
    logic [WORD_W-1:0]       ballot_word;
    logic [LANES*WORD_W-1:0] next_result;
    logic                    next_warn;

    assign op_e        = wcu_op_e'(op);
    assign in_ready    = ~out_valid | out_ready;
    assign accept      = in_valid & in_ready;
    assign is_xfer     = (op_e == OP_SHUFFLE) || (op_e == OP_BCAST);
    assign ballot_word = WORD_W'(pred & active);

    // Per-lane selector: own index for shuffle, common index for broadcast.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            sel_vec[l*IDX_W +: IDX_W] = (op_e == OP_BCAST) ? bcast_lane
                                                           : src_lane[l*IDX_W +: IDX_W];
        end
    end

    // Reduction kind decoded from the opcode.
    always_comb begin
        case (op_e)
            OP_RMIN: kind = RK_MIN;
            OP_RMAX: kind = RK_MAX;
            default: kind = RK_ADD;
        endcase
    end

    wcu_xbar #(
        .LANES  (LANES),
        .IDX_W  (IDX_W),
        .WORD_W (WORD_W)
    ) u_xbar (
        .data_in (lane_data),
        .sel_vec (sel_vec),
        .active  (active),
        .picked  (picked),
        .bad     (bad)
    );

    wcu_reduce #(
        .LANES (LANES)
    ) u_reduce (
        .data_in (lane_data),
        .active  (active),
        .kind    (kind),
        .total   (total)
    );

    // Merge new per-lane values into the held result under the active mask.
    always_comb begin
        next_result = result;
        for (int l = 0; l < LANES; l++) begin
            if (active[l]) begin
                case (op_e)
                    OP_SHUFFLE, OP_BCAST:   next_result[l*WORD_W +: WORD_W] = picked[l*WORD_W +: WORD_W];
                    OP_RADD, OP_RMIN, OP_RMAX: next_result[l*WORD_W +: WORD_W] = total;
                    OP_BALLOT:              next_result[l*WORD_W +: WORD_W] = ballot_word;
                    default:                next_result[l*WORD_W +: WORD_W] = result[l*WORD_W +: WORD_W];
                endcase
            end
        end
    end

    // Warning when an active lane pulled from an unusable source.
    assign next_warn = is_xfer & |(active & bad);

    // Output valid flag of the one-deep result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Result and warning capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            warn   <= 1'b0;
        end else if (accept) begin
            result <= next_result;
            warn   <= next_warn;
        end
    end

endmodule

// File: rtl/wcu_chk.sv
// Property checker for the wave collective unit, bound to every instance.
module wcu_chk #(
    parameter  int LANES = 8,
    localparam int IDX_W = $clog2(LANES) + 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic [2:0]             op,
    input logic [LANES*32-1:0]    lane_data,
    input logic [LANES*IDX_W-1:0] src_lane,
    input logic [IDX_W-1:0]       bcast_lane,
    input logic [LANES-1:0]       pred,
    input logic [LANES-1:0]       active,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [LANES*32-1:0]    result,
    input logic                   warn
);

    logic                acc;
    logic [LANES*32-1:0] keep_mask;

    assign acc = in_valid && in_ready;

    // Expand the inactive lanes into a bit mask over the result vector.
    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            keep_mask[l*32 +: 32] = {32{~active[l]}};
        end
    end

    // R1
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(result) && $stable(warn));

    // R1
    accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> out_valid);

    // R8
    inactive_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> ((result ^ $past(result)) & $past(keep_mask)) == '0);

    // R10
    warn_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op != 3'd0 && op != 3'd1 |=> !warn);

    // R9
    ballot_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op == 3'd5 && active[0] |=> result[31:0] == 32'($past(pred & active)));

    // R3
    shuffle_oob_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc && op == 3'd0 && active[0] && src_lane[IDX_W-1:0] >= IDX_W'(LANES)
        |=> result[31:0] == '0 && warn);

endmodule

bind wave_collective_unit wcu_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/wave_collective_unit_test.sv
module wave_collective_unit_test;

    localparam int LANES = 8;
    localparam int IDX_W = $clog2(LANES) + 1;
    localparam int VW    = LANES * 32;

    typedef struct {
        logic [VW-1:0] res;
        logic          wrn;
        string         tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [2:0]        op = '0;
    logic [VW-1:0]     lane_data = '0;
    logic [LANES*IDX_W-1:0] src_lane = '0;
    logic [IDX_W-1:0]  bcast_lane = '0;
    logic [LANES-1:0]  pred = '0;
    logic [LANES-1:0]  active = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [VW-1:0]     result;
    logic              warn;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    rc = 0;
    bit    stall = 1'b0;
    bit    done = 1'b0;
    logic [31:0] mdl [LANES];
    logic [31:0] seed = 32'h1234_5678;
    exp_t  sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    wave_collective_unit #(.LANES(LANES)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op(op), .lane_data(lane_data), .src_lane(src_lane), .bcast_lane(bcast_lane),
        .pred(pred), .active(active), .out_valid(out_valid), .out_ready(out_ready),
        .result(result), .warn(warn)
    );

    function automatic logic [31:0] rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [VW:0] act, input logic [VW:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Consumer ready pattern, changed just after each rising edge.
    always @(posedge clk) begin
        #2;
        out_ready = !stall && (rc % 4 != 3);
        rc++;
    end

    // Monitor: pop and compare on every completed output handshake.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R1 unexpected result", {warn, result}, '0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(result === e.res && warn === e.wrn, e.tag, {warn, result}, {e.wrn, e.res});
            end
        end
    end

    // Driver: model the request, queue the expected item, drive until accepted.
    task automatic do_op(input logic [2:0] o, input logic [VW-1:0] d,
                         input logic [LANES*IDX_W-1:0] s, input logic [LANES-1:0] p,
                         input logic [LANES-1:0] a, input logic [IDX_W-1:0] b,
                         input string tag);
        exp_t e;
        logic [31:0] sum, mn, mx, val;
        logic w;
        sum = 32'd0; mn = 32'h7FFF_FFFF; mx = 32'h8000_0000; w = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (a[i]) begin
                sum = sum + d[i*32 +: 32];
                if ($signed(d[i*32 +: 32]) < $signed(mn)) mn = d[i*32 +: 32];
                if ($signed(d[i*32 +: 32]) > $signed(mx)) mx = d[i*32 +: 32];
            end
        end
        for (int i = 0; i < LANES; i++) begin
            int si;
            bit ok;
            si  = (o == 3'd1) ? int'(b) : int'(s[i*IDX_W +: IDX_W]);
            ok  = (si < LANES) ? a[si] : 1'b0;
            val = ok ? d[si*32 +: 32] : 32'd0;
            if (a[i]) begin
                case (o)
                    3'd0, 3'd1: begin mdl[i] = val; if (!ok) w = 1'b1; end
                    3'd2: mdl[i] = sum;
                    3'd3: mdl[i] = mn;
                    3'd4: mdl[i] = mx;
                    3'd5: mdl[i] = 32'(p & a);
                    default: ;
                endcase
            end
        end
        for (int i = 0; i < LANES; i++) e.res[i*32 +: 32] = mdl[i];
        e.wrn = w;
        e.tag = tag;
        @(negedge clk);
        op = o; lane_data = d; src_lane = s; pred = p; active = a; bcast_lane = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        sb_q.push_back(e);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    function automatic logic [VW-1:0] ramp(input logic [31:0] base, input logic [31:0] step);
        logic [VW-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*32 +: 32] = base + step * 32'(i);
        return v;
    endfunction

    function automatic logic [LANES*IDX_W-1:0] rot(input int k);
        logic [LANES*IDX_W-1:0] v;
        for (int i = 0; i < LANES; i++) v[i*IDX_W +: IDX_W] = IDX_W'((i + k) % LANES);
        return v;
    endfunction

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", '0, '0);
            summary();
        end
    end

    initial begin
        logic [VW-1:0] held;
        logic [VW-1:0] d;
        logic [LANES*IDX_W-1:0] s;
        for (int i = 0; i < LANES; i++) mdl[i] = 32'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R12: reset state
        check(out_valid === 1'b0 && warn === 1'b0 && result === '0, "R12 reset state",
              {warn, result}, '0);

        // R2: rotate among fully active lanes
        do_op(3'd0, ramp(32'h1000_0000, 32'h0000_0107), rot(1), '0, 8'hFF, '0, "R2 rotate");
        do_op(3'd0, ramp(32'hA5A5_0000, 32'h0001_0001), rot(5), '0, 8'hFF, '0, "R2 rotate by 5");
        // R3 R8: half the lanes inactive, some sources inactive
        do_op(3'd0, ramp(32'h2000_0000, 32'h11), rot(1), '0, 8'b1010_1010, '0, "R3 R8 inactive source");
        // R2 R8: sources all active
        do_op(3'd0, ramp(32'h3000_0000, 32'h22), rot(2), '0, 8'b0101_0101, '0, "R2 R8 sparse mask");
        // R3: out-of-range indices
        s = '0;
        for (int i = 0; i < LANES; i++) s[i*IDX_W +: IDX_W] = IDX_W'(LANES + i);
        do_op(3'd0, ramp(32'h4000_0000, 32'h3), s, '0, 8'hFF, '0, "R3 out of range");
        // R4: broadcast lane 5
        do_op(3'd1, ramp(32'h5000_0000, 32'h1234), '0, '0, 8'hFF, 4'd5, "R4 broadcast");
        // R3 R4: broadcast from inactive lane
        do_op(3'd1, ramp(32'h6000_0000, 32'h1), '0, '0, 8'b1101_1111, 4'd5, "R3 R4 inactive broadcast");
        // R5: wrapping sum
        do_op(3'd2, ramp(32'h4000_0000, 32'h0), '0, '0, 8'hFF, '0, "R5 wrap sum");
        do_op(3'd2, ramp(32'hFFFF_FFF0, 32'h5), '0, '0, 8'b0111_0110, '0, "R5 R8 partial sum");
        // R6 R7: signed min/max with inactive extreme lanes
        d = ramp(32'hFFFF_FF00, 32'h40);
        d[0 +: 32] = 32'h8000_0000;
        d[7*32 +: 32] = 32'h7FFF_FFFF;
        do_op(3'd3, d, '0, '0, 8'b0111_1110, '0, "R6 R7 min");
        do_op(3'd4, d, '0, '0, 8'b0111_1110, '0, "R6 R7 max");
        do_op(3'd3, d, '0, '0, 8'hFF, '0, "R6 min full");
        do_op(3'd4, d, '0, '0, 8'b0000_0110, '0, "R6 max negative");
        // R9: ballot
        do_op(3'd5, '0, '0, 8'b1011_0110, 8'b1110_0111, '0, "R9 ballot");
        // R11: undefined opcodes
        do_op(3'd6, ramp(32'hDEAD_0000, 32'h1), rot(3), 8'hFF, 8'hFF, 4'd9, "R11 opcode 6");
        do_op(3'd7, ramp(32'hBEEF_0000, 32'h1), rot(3), 8'hFF, 8'hFF, 4'd9, "R11 opcode 7");

        // R1: stalled output holds
        wait (sb_q.size() == 0);
        @(negedge clk);
        stall = 1'b1;
        repeat (2) @(negedge clk);
        do_op(3'd2, ramp(32'h1, 32'h1), '0, '0, 8'hFF, '0, "R1 R5 stalled sum");
        @(negedge clk);
        held = result;
        repeat (3) @(negedge clk);
        check(out_valid === 1'b1 && in_ready === 1'b0 && result === held, "R1 stall hold",
              {out_valid, result}, {1'b1, held});
        stall = 1'b0;

        // R10 R2 R3 R5 R6 R9 R11: pseudo-random mix
        for (int k = 0; k < 40; k++) begin
            logic [2:0] o;
            o = 3'(rnd() % 8);
            for (int i = 0; i < LANES; i++) begin
                d[i*32 +: 32] = rnd();
                s[i*IDX_W +: IDX_W] = IDX_W'(rnd() % 10);
            end
            do_op(o, d, s, 8'(rnd()), 8'(rnd()), IDX_W'(rnd() % 10), "R10 mixed ops");
        end

        wait (sb_q.size() == 0);
        repeat (4) @(negedge clk);
        done = 1'b1;
        summary();
    end

endmodule